// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide host side of a three-channel interval timer. It sits between a simple host bus and three separate counting channels, which are not part of it. A host selects the timer window and one of four consecutive offsets: three per-channel data ports and one control port. A second select reaches a system-control port that drives the gate of one channel and reports its output level.

Control words set each channel's mode code, its BCD flag and its byte access pattern, or ask the block to freeze the channel's live count. The block assembles 16-bit count values from byte writes and gives each finished value to its channel with a one-cycle load strobe. It returns counts one byte at a time, either from a frozen copy or from the live count, in the order set by the access pattern. It also raises a one-cycle interrupt request when the first channel's output rises and drives a speaker output.

Read data is combinational during a read cycle. Every side effect of a read, such as advancing the byte order, releasing a frozen copy or flipping the status toggle, takes effect at the clock edge that ends that read cycle.

Top module: `tmr_host_regs`

## Requirements
- R1: With `host_sel` high, offsets 0, 1 and 2 reach the data ports of channels 0, 1 and 2, and offset 3 is the control port. `host_sysctl_sel` reaches the system-control port.
- R2: A control-word write decodes its fields as follows: bits 7:6 select the channel and bits 5:4 select the access (00 freeze, 01 low only, 10 high only, 11 low then high). Bits 3:1 are the mode and bit 0 is the BCD flag. A non-freeze word updates that channel's `ch_mode` and `ch_bcd` one cycle later. A word whose channel field is 3 changes nothing.
- R3: With low-then-high access, the first data write gives the low byte and the second gives the high byte. Only the second write raises the channel's `ch_load` bit for exactly one cycle, with the assembled value on `ch_load_val`.
- R4: With low-only access, each write loads {8'h00, byte}. With high-only access, each write loads {byte, 8'h00}. Every such write raises `ch_load`.
- R5: A non-freeze control word resets both byte pointers of its channel and drops any frozen copy, so the next write is a low byte and the next read returns the low byte.
- R6: A freeze command copies the channel's live count at that edge. Further freeze commands to that channel are ignored until the copy has been fully read.
- R7: With low-then-high access, reads return the low byte first and then the high byte, and the frozen copy is released after the high byte. A single-byte access returns its byte and releases the copy on each read. With no frozen copy, reads return the live count.
- R8: Completing a count write drops any frozen copy of that channel.
- R9: A system-control read returns bit 5 as channel 2 OUT, bit 4 as a toggle, bit 1 as speaker enable and bit 0 as channel 2 gate, with all other bits zero. The toggle inverts after every such read and reads 0 first after reset.
- R10: A system-control write sets channel 2 gate from bit 0 and speaker enable from bit 1. `ch_gate` bits 0 and 1 are always high.
- R11: `irq` is high in the cycle where `ch_out[0]` is high and was low at the previous clock edge, and is low otherwise.
- R12: `spk_out` is channel 2 OUT ANDed with the speaker enable bit.
- R13: After reset every channel has mode 3, BCD flag 0, low-then-high access, a load value of zero and cleared byte pointers. `ch_gate` is 3'b011, and `irq`, `spk_out` and `ch_load` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Selects the four-offset timer window |
| host_sysctl_sel | input | 1 | Selects the system-control port |
| host_addr | input | 2 | Offset within the timer window |
| host_wr | input | 1 | Write cycle |
| host_rd | input | 1 | Read cycle |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte, valid during a read cycle |
| ch_count | input | 48 | Live counts, channel n in bits 16n+15:16n |
| ch_out | input | 3 | Channel OUT levels |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_load_val | output | 48 | Count value per channel, channel n in bits 16n+15:16n |
| ch_mode | output | 9 | Mode code per channel, channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_gate | output | 3 | Gate level per channel |
| irq | output | 1 | Interrupt request on a rising channel 0 OUT |
| spk_out | output | 1 | Speaker drive |

## Verification
Two pairs of events can fall in the same cycle. The first is a freeze command captured at the very edge after which the live count changes. The bench moves `ch_count` right after the freeze cycle and expects the bytes read later to come from the value present at that edge. The second is a rise of channel 0 OUT during the cycle of a completing count write. The bench raises `ch_out[0]` together with the second data byte and expects both the interrupt pulse in that cycle and the load strobe with the assembled value in the next.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

   typedef enum logic [1:0] {
      ACC_FREEZE = 2'b00,
      ACC_LO     = 2'b01,
      ACC_HI     = 2'b10,
      ACC_LOHI   = 2'b11
   } acc_e;

   typedef struct packed {
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctl_word_t;

   localparam logic [2:0] MODE_SQUARE = 3'd3;
   localparam int         CTL_W       = 8;

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
   import tmr_host_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 2,
   parameter int BYTE_W = 8
) (
   input  logic              host_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [NUM_CH-1:0] dat_wr,
   output logic [NUM_CH-1:0] dat_rd,
   output logic [NUM_CH-1:0] cw_set,
   output logic [NUM_CH-1:0] cw_freeze,
   output ctl_word_t         cw
);

   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

   logic ctl_hit;

   assign cw      = ctl_word_t'(host_wdata[CTL_W-1:0]);
   assign ctl_hit = host_sel & host_wr & (host_addr == CTL_ADDR);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic port_hit;
      logic sel_hit;
      assign port_hit     = host_sel & (host_addr == ADDR_W'(i));
      assign sel_hit      = ctl_hit & (cw.sel == 2'(i));
      assign dat_wr[i]    = port_hit & host_wr;
      assign dat_rd[i]    = port_hit & host_rd;
      assign cw_set[i]    = sel_hit & (cw.acc != ACC_FREEZE);
      assign cw_freeze[i] = sel_hit & (cw.acc == ACC_FREEZE);
   end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
   import tmr_host_pkg::*;
#(
   parameter  int BYTE_W = 8,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_set,
   input  logic              cw_freeze,
   input  acc_e              cw_acc,
   input  logic [2:0]        cw_mode,
   input  logic              cw_bcd,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic [2:0]        mode,
   output logic              bcd,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [BYTE_W-1:0] rbyte
);

   acc_e              acc_q;
   logic [2:0]        mode_q;
   logic              bcd_q;
   logic              wr_hi_q;
   logic [BYTE_W-1:0] lo_q;
   logic              rd_hi_q;
   logic              frz_full_q;
   logic [CNT_W-1:0]  frz_q;
   logic              load_q;
   logic [CNT_W-1:0]  load_val_q;

   logic              wr_done;
   logic [CNT_W-1:0]  wr_val;
   logic              rd_release;
   logic [CNT_W-1:0]  rd_src;
   logic              rd_upper;

   always_comb begin
      wr_done = 1'b0;
      wr_val  = '0;
      unique case (acc_q)
         ACC_LO: begin
            wr_done = dat_wr;
            wr_val  = {{BYTE_W{1'b0}}, wdata};
         end
         ACC_HI: begin
            wr_done = dat_wr;
            wr_val  = {wdata, {BYTE_W{1'b0}}};
         end
         default: begin
            wr_done = dat_wr & wr_hi_q;
            wr_val  = {wdata, lo_q};
         end
      endcase
   end

   assign rd_src     = frz_full_q ? frz_q : live_cnt;
   assign rd_upper   = (acc_q == ACC_HI) | ((acc_q == ACC_LOHI) & rd_hi_q);
   assign rbyte      = rd_upper ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
   assign rd_release = dat_rd & ((acc_q != ACC_LOHI) | rd_hi_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= ACC_LOHI;
         mode_q     <= MODE_SQUARE;
         bcd_q      <= 1'b0;
         wr_hi_q    <= 1'b0;
         lo_q       <= '0;
         rd_hi_q    <= 1'b0;
         frz_full_q <= 1'b0;
         frz_q      <= '0;
         load_q     <= 1'b0;
         load_val_q <= '0;
      end else begin
         load_q <= wr_done;
         if (cw_set) begin
            acc_q      <= cw_acc;
            mode_q     <= cw_mode;
            bcd_q      <= cw_bcd;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            frz_full_q <= 1'b0;
         end else if (cw_freeze) begin
            if (!frz_full_q) begin
               frz_q      <= live_cnt;
               frz_full_q <= 1'b1;
               rd_hi_q    <= 1'b0;
            end
         end else if (dat_wr) begin
            if ((acc_q == ACC_LOHI) && !wr_hi_q) begin
               lo_q    <= wdata;
               wr_hi_q <= 1'b1;
            end
            if (wr_done) begin
               load_val_q <= wr_val;
               wr_hi_q    <= 1'b0;
               rd_hi_q    <= 1'b0;
               frz_full_q <= 1'b0;
            end
         end else if (dat_rd) begin
            if (acc_q == ACC_LOHI) begin
               rd_hi_q <= !rd_hi_q;
            end
            if (rd_release) begin
               frz_full_q <= 1'b0;
            end
         end
      end
   end

   assign mode     = mode_q;
   assign bcd      = bcd_q;
   assign load     = load_q;
   assign load_val = load_val_q;

endmodule

// File: rtl/tmr_sys_port.sv
module tmr_sys_port #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_wr,
   input  logic              sys_rd,
   input  logic              wr_gate_bit,
   input  logic              wr_spk_bit,
   input  logic              chan_out,
   input  logic              irq_src,
   output logic              gate,
   output logic              spk_out,
   output logic              irq,
   output logic              refresh,
   output logic [BYTE_W-1:0] status
);

   localparam int B_OUT  = 5;
   localparam int B_TOG  = 4;
   localparam int B_SPK  = 1;
   localparam int B_GATE = 0;

   logic gate_q;
   logic spk_en_q;
   logic tog_q;
   logic src_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q     <= 1'b0;
         spk_en_q   <= 1'b0;
         tog_q      <= 1'b0;
         src_prev_q <= 1'b1;
      end else begin
         src_prev_q <= irq_src;
         if (sys_wr) begin
            gate_q   <= wr_gate_bit;
            spk_en_q <= wr_spk_bit;
         end
         if (sys_rd) begin
            tog_q <= !tog_q;
         end
      end
   end

   always_comb begin
      status         = '0;
      status[B_OUT]  = chan_out;
      status[B_TOG]  = tog_q;
      status[B_SPK]  = spk_en_q;
      status[B_GATE] = gate_q;
   end

   assign gate    = gate_q;
   assign spk_out = chan_out & spk_en_q;
   assign irq     = irq_src & ~src_prev_q;
   assign refresh = tog_q;

endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
   import tmr_host_pkg::*;
#(
   parameter  int NUM_CH  = 3,
   parameter  int BYTE_W  = 8,
   parameter  int GATE_CH = 2,
   parameter  int IRQ_CH  = 0,
   localparam int CNT_W   = 2 * BYTE_W,
   localparam int ADDR_W  = $clog2(NUM_CH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_sel,
   input  logic                    host_sysctl_sel,
   input  logic [ADDR_W-1:0]       host_addr,
   input  logic                    host_wr,
   input  logic                    host_rd,
   input  logic [BYTE_W-1:0]       host_wdata,
   output logic [BYTE_W-1:0]       host_rdata,
   input  logic [NUM_CH*CNT_W-1:0] ch_count,
   input  logic [NUM_CH-1:0]       ch_out,
   output logic [NUM_CH-1:0]       ch_load,
   output logic [NUM_CH*CNT_W-1:0] ch_load_val,
   output logic [NUM_CH*3-1:0]     ch_mode,
   output logic [NUM_CH-1:0]       ch_bcd,
   output logic [NUM_CH-1:0]       ch_gate,
   output logic                    irq,
   output logic                    spk_out
);

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_num_ch
      $error("NUM_CH must be 1..3: the channel field code 3 is reserved");
   end
   if (BYTE_W != CTL_W) begin : g_bad_byte_w
      $error("BYTE_W must equal the control word width");
   end
   if (GATE_CH >= NUM_CH || IRQ_CH >= NUM_CH) begin : g_bad_ch_idx
      $error("GATE_CH and IRQ_CH must name existing channels");
   end

   logic [NUM_CH-1:0] dat_wr;
   logic [NUM_CH-1:0] dat_rd;
   logic [NUM_CH-1:0] cw_set;
   logic [NUM_CH-1:0] cw_freeze;
   ctl_word_t         cw;
   logic [BYTE_W-1:0] chan_rbyte [NUM_CH];
   logic [BYTE_W-1:0] chan_rd_mux;
   logic [BYTE_W-1:0] sys_status;
   logic              sys_gate;
   logic              sys_refresh;

   tmr_ctl_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) u_dec (
      .host_sel   (host_sel),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .dat_wr     (dat_wr),
      .dat_rd     (dat_rd),
      .cw_set     (cw_set),
      .cw_freeze  (cw_freeze),
      .cw         (cw)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_chan_port #(
         .BYTE_W (BYTE_W)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .cw_set    (cw_set[i]),
         .cw_freeze (cw_freeze[i]),
         .cw_acc    (cw.acc),
         .cw_mode   (cw.mode),
         .cw_bcd    (cw.bcd),
         .dat_wr    (dat_wr[i]),
         .dat_rd    (dat_rd[i]),
         .wdata     (host_wdata),
         .live_cnt  (ch_count[i*CNT_W +: CNT_W]),
         .mode      (ch_mode[i*3 +: 3]),
         .bcd       (ch_bcd[i]),
         .load      (ch_load[i]),
         .load_val  (ch_load_val[i*CNT_W +: CNT_W]),
         .rbyte     (chan_rbyte[i])
      );

      if (i == GATE_CH) begin : g_gate_ctl
         assign ch_gate[i] = sys_gate;
      end else begin : g_gate_tied
         assign ch_gate[i] = 1'b1;
      end
   end

   tmr_sys_port #(
      .BYTE_W (BYTE_W)
   ) u_sys (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_wr      (host_sysctl_sel & host_wr),
      .sys_rd      (host_sysctl_sel & host_rd),
      .wr_gate_bit (host_wdata[0]),
      .wr_spk_bit  (host_wdata[1]),
      .chan_out    (ch_out[GATE_CH]),
      .irq_src     (ch_out[IRQ_CH]),
      .gate        (sys_gate),
      .spk_out     (spk_out),
      .irq         (irq),
      .refresh     (sys_refresh),
      .status      (sys_status)
   );

   always_comb begin
      chan_rd_mux = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (host_addr == ADDR_W'(i)) begin
            chan_rd_mux = chan_rbyte[i];
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (host_sysctl_sel) begin
            host_rdata = sys_status;
         end else if (host_sel) begin
            host_rdata = chan_rd_mux;
         end
      end
   end

endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
   parameter int NUM_CH  = 3,
   parameter int ADDR_W  = 2,
   parameter int BYTE_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_sysctl_sel,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [BYTE_W-1:0] host_wdata,
   input logic [NUM_CH-1:0] ch_load,
   input logic [2:0]        mode0,
   input logic              gate_ctl,
   input logic              irq_src,
   input logic              irq,
   input logic              refresh
);

   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

   // R3: a load strobe only follows a data-port write
   assert_load_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_load) |-> $past(host_sel && host_wr && (host_addr < CTL_ADDR)));

   // R3: at most one channel loads in a cycle
   assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load));

   // R2: a non-freeze control word for channel 0 sets its mode next cycle
   assert_mode_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && (host_addr == CTL_ADDR) &&
       (host_wdata[7:6] == 2'b00) && (host_wdata[5:4] != 2'b00))
      |=> (mode0 == $past(host_wdata[3:1])));

   // R9: every system-control read flips the toggle bit
   assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sysctl_sel && host_rd) |=> (refresh != $past(refresh)));

   // R10: a system-control write sets the controlled gate from bit 0
   assert_gate_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sysctl_sel && host_wr) |=> (gate_ctl == $past(host_wdata[0])));

   // R11: an interrupt request only accompanies a fresh rise
   assert_irq_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_src && !$past(irq_src)));

endmodule

bind tmr_host_regs tmr_host_regs_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .host_sel        (host_sel),
   .host_sysctl_sel (host_sysctl_sel),
   .host_addr       (host_addr),
   .host_wr         (host_wr),
   .host_rd         (host_rd),
   .host_wdata      (host_wdata),
   .ch_load         (ch_load),
   .mode0           (ch_mode[2:0]),
   .gate_ctl        (ch_gate[GATE_CH]),
   .irq_src         (ch_out[IRQ_CH]),
   .irq             (irq),
   .refresh         (sys_refresh)
);

// File: tb/tmr_host_regs_test.sv
module tmr_host_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_sysctl_sel = 1'b0;
   logic [1:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [47:0] ch_count = '0;
   logic [2:0]  ch_out = 3'b111;
   logic [2:0]  ch_load;
   logic [47:0] ch_load_val;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;
   logic [2:0]  ch_gate;
   logic        irq;
   logic        spk_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   tmr_host_regs uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .host_sel        (host_sel),
      .host_sysctl_sel (host_sysctl_sel),
      .host_addr       (host_addr),
      .host_wr         (host_wr),
      .host_rd         (host_rd),
      .host_wdata      (host_wdata),
      .host_rdata      (host_rdata),
      .ch_count        (ch_count),
      .ch_out          (ch_out),
      .ch_load         (ch_load),
      .ch_load_val     (ch_load_val),
      .ch_mode         (ch_mode),
      .ch_bcd          (ch_bcd),
      .ch_gate         (ch_gate),
      .irq             (irq),
      .spk_out         (spk_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per read cycle
   always @(negedge clk) begin
      if (rst_n && host_rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected read", {56'h0, host_rdata}, 64'h0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(host_rdata === e, t, {56'h0, host_rdata}, {56'h0, e});
         end
      end
   end

   task automatic op_wr(input bit sys, input logic [1:0] a, input logic [7:0] d);
      host_sel = !sys;
      host_sysctl_sel = sys;
      host_addr = a;
      host_wdata = d;
      host_wr = 1'b1;
      @(posedge clk);
      #1;
      host_wr = 1'b0;
      host_sel = 1'b0;
      host_sysctl_sel = 1'b0;
   endtask

   task automatic op_rd(input bit sys, input logic [1:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      host_sel = !sys;
      host_sysctl_sel = sys;
      host_addr = a;
      host_rd = 1'b1;
      @(posedge clk);
      #1;
      host_rd = 1'b0;
      host_sel = 1'b0;
      host_sysctl_sel = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // reset state
      chk(ch_mode == 9'b011_011_011, "R13 modes", ch_mode, 9'b011_011_011);
      chk(ch_load_val == 48'h0, "R13 load value", ch_load_val, 0);
      chk(ch_bcd == 3'b000, "R13 bcd", ch_bcd, 0);
      chk(ch_gate == 3'b011, "R13 gates", ch_gate, 3'b011);
      chk({irq, spk_out, ch_load} == 5'b0, "R13 irq/spk/load", {irq, spk_out, ch_load}, 0);

      // status byte and toggle
      op_rd(1'b1, 2'd0, 8'h20, "R9 status first read");
      op_rd(1'b1, 2'd0, 8'h30, "R9 status toggled");

      // channel 0: mode 2, low then high
      op_wr(1'b0, 2'd3, 8'h34);
      chk(ch_mode[2:0] == 3'd2, "R2 ch0 mode", ch_mode[2:0], 2);
      op_wr(1'b0, 2'd0, 8'h34);
      chk(ch_load == 3'b000, "R3 no load after low byte", ch_load, 0);
      op_wr(1'b0, 2'd0, 8'h12);
      chk(ch_load == 3'b001, "R3 ch0 load strobe", ch_load, 1);
      chk(ch_load_val[15:0] == 16'h1234, "R3 ch0 value R1 offset 0", ch_load_val[15:0], 16'h1234);
      @(posedge clk);
      #1;
      chk(ch_load == 3'b000, "R3 strobe one cycle", ch_load, 0);

      // control word resets the write pointer mid-pair
      op_wr(1'b0, 2'd1, 8'hAA);
      op_wr(1'b0, 2'd3, 8'h76);
      op_wr(1'b0, 2'd1, 8'h55);
      chk(ch_load == 3'b000, "R5 pointer reset no load", ch_load, 0);
      op_wr(1'b0, 2'd1, 8'h66);
      chk(ch_load == 3'b010, "R5 ch1 load", ch_load, 3'b010);
      chk(ch_load_val[31:16] == 16'h6655, "R5 ch1 value R1 offset 1", ch_load_val[31:16], 16'h6655);

      // single-byte accesses on channel 2
      op_wr(1'b0, 2'd3, 8'h90);
      op_wr(1'b0, 2'd2, 8'h7F);
      chk(ch_load == 3'b100, "R4 low-only load", ch_load, 3'b100);
      chk(ch_load_val[47:32] == 16'h007F, "R4 low-only value", ch_load_val[47:32], 16'h007F);
      op_wr(1'b0, 2'd3, 8'hA1);
      chk(ch_bcd == 3'b100, "R2 bcd flag", ch_bcd, 3'b100);
      op_wr(1'b0, 2'd2, 8'h7F);
      chk(ch_load_val[47:32] == 16'h7F00, "R4 high-only value", ch_load_val[47:32], 16'h7F00);

      // live reads on channel 0
      ch_count[15:0] = 16'hBEEF;
      op_rd(1'b0, 2'd0, 8'hEF, "R7 live low");
      op_rd(1'b0, 2'd0, 8'hBE, "R7 live high");

      // freeze, count moves right after, repeat freeze ignored
      op_wr(1'b0, 2'd3, 8'h00);
      ch_count[15:0] = 16'h1111;
      op_wr(1'b0, 2'd3, 8'h00);
      chk(ch_mode[2:0] == 3'd2, "R2 freeze keeps mode", ch_mode[2:0], 2);
      ch_count[15:0] = 16'h2233;
      op_rd(1'b0, 2'd0, 8'hEF, "R6 frozen low");
      op_rd(1'b0, 2'd0, 8'hBE, "R6 frozen high");
      op_rd(1'b0, 2'd0, 8'h33, "R7 released low");
      op_rd(1'b0, 2'd0, 8'h22, "R7 released high");

      // count write drops a held freeze
      op_wr(1'b0, 2'd3, 8'h00);
      op_wr(1'b0, 2'd0, 8'h01);
      op_wr(1'b0, 2'd0, 8'h00);
      chk(ch_load_val[15:0] == 16'h0001, "R8 reload value", ch_load_val[15:0], 1);
      ch_count[15:0] = 16'h4455;
      op_rd(1'b0, 2'd0, 8'h55, "R8 live after write low");
      op_rd(1'b0, 2'd0, 8'h44, "R8 live after write high");

      // high-only reads on channel 2
      ch_count[47:32] = 16'hC3A5;
      op_rd(1'b0, 2'd2, 8'hC3, "R7 high-only live R1 offset 2");
      op_wr(1'b0, 2'd3, 8'h80);
      ch_count[47:32] = 16'h0000;
      op_rd(1'b0, 2'd2, 8'hC3, "R6 high-only frozen");
      op_rd(1'b0, 2'd2, 8'h00, "R7 high-only released");

      // channel field 3 ignored
      op_wr(1'b0, 2'd3, 8'hF6);
      chk(ch_mode == 9'b000_011_010, "R2 channel 3 ignored", ch_mode, 9'b000_011_010);
      chk(ch_load == 3'b000, "R2 channel 3 no load", ch_load, 0);

      // control word resets the read pointer
      ch_count[31:16] = 16'h5A69;
      op_rd(1'b0, 2'd1, 8'h69, "R7 ch1 low");
      op_wr(1'b0, 2'd3, 8'h76);
      op_rd(1'b0, 2'd1, 8'h69, "R5 read pointer reset low");
      op_rd(1'b0, 2'd1, 8'h5A, "R5 read pointer reset high");

      // system-control write, gate and speaker
      op_wr(1'b1, 2'd0, 8'h03);
      chk(ch_gate == 3'b111, "R10 gate set", ch_gate, 3'b111);
      chk(spk_out == 1'b1, "R12 speaker on", spk_out, 1);
      ch_out[2] = 1'b0;
      #1;
      chk(spk_out == 1'b0, "R12 speaker follows out", spk_out, 0);
      op_rd(1'b1, 2'd0, 8'h03, "R9 status after write");
      op_wr(1'b1, 2'd0, 8'h00);
      chk(ch_gate == 3'b011, "R10 gate cleared", ch_gate, 3'b011);

      // interrupt edge
      ch_out[0] = 1'b0;
      @(posedge clk);
      #1;
      chk(irq == 1'b0, "R11 falling no irq", irq, 0);
      ch_out[0] = 1'b1;
      #1;
      chk(irq == 1'b1, "R11 rising irq", irq, 1);
      @(posedge clk);
      #1;
      chk(irq == 1'b0, "R11 irq one cycle", irq, 0);
      ch_out[0] = 1'b0;
      @(posedge clk);
      #1;

      // rise together with a completing count write
      op_wr(1'b0, 2'd1, 8'h10);
      ch_out[0] = 1'b1;
      host_sel = 1'b1;
      host_addr = 2'd1;
      host_wdata = 8'h20;
      host_wr = 1'b1;
      #1;
      chk(irq == 1'b1, "R11 irq with write", irq, 1);
      @(posedge clk);
      #1;
      host_wr = 1'b0;
      host_sel = 1'b0;
      chk(ch_load == 3'b010, "R3 load with irq", ch_load, 3'b010);
      chk(ch_load_val[31:16] == 16'h2010, "R3 value with irq", ch_load_val[31:16], 16'h2010);
      chk(irq == 1'b0, "R11 irq ended", irq, 0);

      repeat (2) @(posedge clk);
      chk(exp_q.size() == 0, "R7 all reads observed", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule